// File: doc/BRIEF.md
# PHY Register Access Handshake Master

This block lets on-chip logic read and write 16-bit registers that live inside a serial PHY and are reachable only through a pair of side-band words: a 20-bit control word driven by the block and a 17-bit status word returned by the PHY. Every step of an access is a full four-phase exchange. The block raises a strobe, waits until the PHY acknowledges, drops the strobe and then waits until the acknowledge falls again.

A caller presents an address, write data and a read/write select. It pulses `cmd_valid` while `busy` is low. A write moves through an address capture, a data capture and a write strobe. A read moves through an address capture and then a read strobe, and the read data is taken from the status word at the moment the acknowledge rises. Each wait for the acknowledge polls a bounded number of times at a programmable spacing. If the expected level never arrives, the access is abandoned, the control word is cleared and a sticky timeout flag is raised.

Top module: `phy_reg_master`

## Requirements
- R1: After reset, `phy_ctrl` is 0, `busy` is 0, `rsp_done` is 0 and `rsp_timeout` is 0.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` is 1 from the following cycle until the access ends. A `cmd_valid` seen while `busy` is 1 has no effect on the control word sequence or on the PHY registers.
- R3: In `phy_ctrl`, bits 15:0 carry the address or data value, bit 16 is capture-address, bit 17 is capture-data, bit 18 is write and bit 19 is read, and at most one of bits 19:16 is 1 at a time. In `phy_stat`, bit 16 is the acknowledge and bits 15:0 are the read data.
- R4: Both kinds of access begin with an address phase. The address is shown with no strobe, then the address is shown with capture-address set until the acknowledge is 1, then the address is shown with no strobe until the acknowledge is 0.
- R5: After the address phase, a write shows the data with no strobe, then the data with capture-data until the acknowledge is 1, then the data alone until the acknowledge is 0. It then shows the write strobe with a zero value field until the acknowledge is 1, then the data alone until the acknowledge is 0, and finally the control word becomes 0.
- R6: After the address phase, a read shows the read strobe with a zero value field until the acknowledge is 1. It captures `phy_stat[15:0]` at that point, shows 0 until the acknowledge is 0, and then presents the captured value on `rsp_rdata`.
- R7: Each acknowledge wait polls first in the first cycle that the new control word is shown, then every POLL_GAP cycles, for at most POLL_LIMIT (default 10) polls. A match on the last poll still lets the access continue.
- R8: If POLL_LIMIT polls all miss, the access ends at the edge of the last poll. `phy_ctrl` becomes 0, `busy` falls and `rsp_timeout` becomes 1. `rsp_timeout` stays 1 until the next command is accepted and is 0 from the cycle after that acceptance.
- R9: A completed access pulses `rsp_done` for exactly one cycle. `busy` is 0 in that same cycle, and no done pulse is given for an abandoned access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_write | input | 1 | 1 selects write, 0 selects read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | An access is in progress |
| phy_ctrl | output | 20 | Control word to the PHY (value field and four strobes) |
| phy_stat | input | 17 | Status word from the PHY (acknowledge and read data) |
| rsp_rdata | output | 16 | Data returned by the last completed read |
| rsp_done | output | 1 | One-cycle pulse when an access completes |
| rsp_timeout | output | 1 | Sticky flag for an abandoned access |

## Verification
Counting the acceptance edge as edge 0, `busy` is due one cycle later. A timeout in the first acknowledge-high wait is due at edge 2 + 9·POLL_GAP, and a timeout in the first acknowledge-low wait is due at edge 3 + 9·POLL_GAP. The bench counts edges from acceptance and compares these exact counts. It also samples 1 ns after each edge, so the cleared timeout flag, the one-cycle done pulse and `busy` falling in the same cycle are all seen on the edge where they are due. Protocol order is checked by logging every change of `phy_ctrl` at the falling edge and comparing the log with the sequence expected for each access. An acknowledge is held back until exactly the tenth poll to probe the retry bound.

// File: rtl/phy_acc_pkg.sv
// Shared types for the PHY register access master.
// Assumes a 4-bit strobe nibble sitting directly above the value field.
package phy_acc_pkg;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_ADDR = 2'd1,
        SRC_DATA = 2'd2
    } src_e;

    // strobe nibble positions (nibble bit 0 is control bit 16)
    localparam logic [3:0] STB_NONE = 4'b0000;
    localparam logic [3:0] STB_CAPA = 4'b0001;
    localparam logic [3:0] STB_CAPD = 4'b0010;
    localparam logic [3:0] STB_WR   = 4'b0100;
    localparam logic [3:0] STB_RD   = 4'b1000;

    localparam int STEP_W = 4;

    typedef struct packed {
        src_e       src;     // what fills the value field
        logic [3:0] strobe;  // strobe nibble
        logic       waits;   // step waits for an acknowledge level
        logic       want;    // acknowledge level waited for
        logic       last;    // final step of the access
        logic       grab;    // capture read data on success
    } step_t;

endpackage

// File: rtl/phy_acc_steps.sv
// Step table: maps access kind and step index to the control word recipe.
// Assumes the caller never indexes past the step flagged as last.
module phy_acc_steps
    import phy_acc_pkg::*;
(
    input  logic              is_write,
    input  logic [STEP_W-1:0] idx,
    output step_t             desc
);

    // purpose: decode one step of the write or read recipe
    always_comb begin
        desc = '{src: SRC_ZERO, strobe: STB_NONE, waits: 1'b0,
                 want: 1'b0, last: 1'b0, grab: 1'b0};
        case ({is_write, idx})
            // address phase, shared by both access kinds
            5'h00, 5'h10: desc.src = SRC_ADDR;
            5'h01, 5'h11: begin desc.src = SRC_ADDR; desc.strobe = STB_CAPA;
                                desc.waits = 1'b1; desc.want = 1'b1; end
            5'h02, 5'h12: begin desc.src = SRC_ADDR; desc.waits = 1'b1; end
            // read tail
            5'h03: begin desc.strobe = STB_RD; desc.waits = 1'b1;
                         desc.want = 1'b1; desc.grab = 1'b1; end
            5'h04: begin desc.waits = 1'b1; desc.last = 1'b1; end
            // write tail
            5'h13: desc.src = SRC_DATA;
            5'h14: begin desc.src = SRC_DATA; desc.strobe = STB_CAPD;
                         desc.waits = 1'b1; desc.want = 1'b1; end
            5'h15: begin desc.src = SRC_DATA; desc.waits = 1'b1; end
            5'h16: begin desc.strobe = STB_WR; desc.waits = 1'b1;
                         desc.want = 1'b1; end
            5'h17: begin desc.src = SRC_DATA; desc.waits = 1'b1; end
            5'h18: desc.last = 1'b1;
            default: desc.last = 1'b1;
        endcase
    end

endmodule

// File: rtl/phy_acc_poller.sv
// Acknowledge poller: samples the match input at a fixed spacing and gives
// up after a bounded number of misses. Assumes arm pulses on each step entry.
module phy_acc_poller #(
    parameter int GAP   = 250,
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic en,
    input  logic ack_ok,
    output logic hit,
    output logic give_up
);

    localparam int GAP_W = (GAP > 1) ? $clog2(GAP + 1) : 1;
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

    logic [GAP_W-1:0] gap_cnt;
    logic [CNT_W-1:0] poll_cnt;
    logic             poll_now;
    logic             last_poll;

    assign poll_now  = en && (gap_cnt == '0);
    assign last_poll = (poll_cnt == CNT_W'(LIMIT - 1));
    assign hit       = poll_now && ack_ok;
    assign give_up   = poll_now && !ack_ok && last_poll;

    // purpose: count spacing between polls and the number of misses
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            gap_cnt  <= '0;
            poll_cnt <= '0;
        end else if (poll_now && !ack_ok && !last_poll) begin
            poll_cnt <= poll_cnt + 1'b1;
            gap_cnt  <= GAP_W'(GAP - 1);
        end else if (en && gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < CNT_W'(LIMIT));

endmodule

// File: rtl/phy_reg_master.sv
// PHY register access master: runs the four-phase strobe/acknowledge
// recipe for one read or write per command. Assumes phy_stat is synchronous
// to clk. POLL_GAP defaults to 1 us at a 250 MHz clock.
module phy_reg_master
    import phy_acc_pkg::*;
#(
    parameter int FIELD_W    = 16,
    parameter int POLL_GAP   = 250,
    parameter int POLL_LIMIT = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic [FIELD_W-1:0] cmd_addr,
    input  logic [FIELD_W-1:0] cmd_wdata,
    output logic               busy,
    output logic [FIELD_W+3:0] phy_ctrl,
    input  logic [FIELD_W:0]   phy_stat,
    output logic [FIELD_W-1:0] rsp_rdata,
    output logic               rsp_done,
    output logic               rsp_timeout
);

    localparam int ACK_BIT = FIELD_W;

    logic               busy_q, is_wr_q, done_q, tout_q;
    logic [STEP_W-1:0]  step_q;
    logic [FIELD_W-1:0] addr_q, data_q, rdata_q;
    logic [FIELD_W-1:0] value;
    logic               accept, advance, hit, give_up;
    step_t              d;

    phy_acc_steps u_steps (
        .is_write (is_wr_q),
        .idx      (step_q),
        .desc     (d)
    );

    phy_acc_poller #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (advance || accept),
        .en      (busy_q && d.waits),
        .ack_ok  (phy_stat[ACK_BIT] == d.want),
        .hit     (hit),
        .give_up (give_up)
    );

    assign accept  = cmd_valid && !busy_q;
    assign advance = busy_q && (!d.waits || hit);

    // purpose: build the value field of the control word for this step
    always_comb begin
        case (d.src)
            SRC_ADDR: value = addr_q;
            SRC_DATA: value = data_q;
            default:  value = '0;
        endcase
    end

    assign phy_ctrl    = busy_q ? {d.strobe, value} : '0;
    assign busy        = busy_q;
    assign rsp_rdata   = rdata_q;
    assign rsp_done    = done_q;
    assign rsp_timeout = tout_q;

    // purpose: command intake, step progression and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            is_wr_q <= 1'b0;
            step_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                is_wr_q <= cmd_write;
                addr_q  <= cmd_addr;
                data_q  <= cmd_wdata;
                step_q  <= '0;
                tout_q  <= 1'b0;
            end else if (give_up) begin
                busy_q <= 1'b0;
                tout_q <= 1'b1;
            end else if (advance) begin
                if (d.grab) rdata_q <= phy_stat[FIELD_W-1:0];
                if (d.last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[FIELD_W+3:FIELD_W]));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !busy && !rsp_timeout);

    assert_timeout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_timeout) |-> !busy && phy_ctrl == '0);

    assert_hold_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(addr_q) && $stable(data_q) && $stable(is_wr_q));

endmodule

// File: tb/phy_reg_master_test.sv
module phy_reg_master_test;

    localparam int GAP   = 8;
    localparam int LIMIT = 10;
    localparam logic [19:0] S_CA = 20'h10000;
    localparam logic [19:0] S_CD = 20'h20000;
    localparam logic [19:0] S_WR = 20'h40000;
    localparam logic [19:0] S_RD = 20'h80000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic        busy, rsp_done, rsp_timeout;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;
    logic [15:0] rsp_rdata;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    phy_reg_master #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .phy_ctrl(phy_ctrl), .phy_stat(phy_stat), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .rsp_timeout(rsp_timeout)
    );

    // PHY responder: ack follows any strobe one cycle later; 16-word register file
    logic [15:0] mem [16];
    logic [15:0] cap_a, cap_d;
    logic        ack_q;
    logic        force_en = 1'b0, force_val = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            cap_a <= '0;
            cap_d <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'h5A00 + 16'(i);
        end else begin
            ack_q <= |phy_ctrl[19:16];
            if (phy_ctrl[16]) cap_a <= phy_ctrl[15:0];
            if (phy_ctrl[17]) cap_d <= phy_ctrl[15:0];
            if (phy_ctrl[18]) mem[cap_a[3:0]] <= cap_d;
        end
    end
    assign phy_stat = {force_en ? force_val : ack_q, mem[cap_a[3:0]]};

    // log every change of the control word, sampled at the falling edge
    logic [19:0] got_log [64];
    int          got_n = 0;
    logic [19:0] got_last = '0;
    always @(negedge clk) begin
        if (phy_ctrl !== got_last) begin
            if (got_n < 64) got_log[got_n] = phy_ctrl;
            got_n++;
            got_last = phy_ctrl;
        end
    end

    logic [19:0] exp_log [16];
    int          exp_n;
    logic [19:0] exp_last;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic exp_clear();
        exp_n = 0;
        exp_last = '0;
    endtask

    task automatic exp_add(input logic [19:0] v);
        if (v != exp_last) begin
            exp_log[exp_n] = v;
            exp_n++;
            exp_last = v;
        end
    endtask

    task automatic check_seq(input int base, input string req);
        int cnt = got_n - base;
        check(cnt == exp_n, req, "control word change count", cnt, exp_n);
        if (cnt == exp_n)
            for (int k = 0; k < exp_n; k++)
                check(got_log[base + k] == exp_log[k], req, "control word step",
                      {12'h0, got_log[base + k]}, {12'h0, exp_log[k]});
    endtask

    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] dt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = dt;
        @(posedge clk);   // acceptance edge
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_end(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!rsp_done && !rsp_timeout && n < 20000);
    endtask

    task automatic t_reset();
        check(phy_ctrl == 0, "R1", "ctrl after reset", phy_ctrl, 0);
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(rsp_done == 0, "R1", "done after reset", rsp_done, 0);
        check(rsp_timeout == 0, "R1", "timeout after reset", rsp_timeout, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] dt);
        int base, n;
        exp_clear();
        exp_add({4'h0, a}); exp_add(S_CA | a); exp_add({4'h0, a});
        exp_add({4'h0, dt}); exp_add(S_CD | dt); exp_add({4'h0, dt});
        exp_add(S_WR); exp_add({4'h0, dt}); exp_add(20'h0);
        base = got_n;
        issue(1'b1, a, dt);
        check(busy == 1, "R2", "busy after accept", busy, 1);
        wait_end(n);
        check(rsp_done == 1, "R9", "write done", rsp_done, 1);
        check(busy == 0, "R9", "busy low with done", busy, 0);
        check(rsp_timeout == 0, "R8", "no timeout on write", rsp_timeout, 0);
        @(posedge clk); #1;
        check(rsp_done == 0, "R9", "done one cycle", rsp_done, 0);
        check_seq(base, "R3/R4/R5 write");
    endtask

    task automatic t_read(input logic [15:0] a, input logic [15:0] exp_d);
        int base, n;
        exp_clear();
        exp_add({4'h0, a}); exp_add(S_CA | a); exp_add({4'h0, a});
        exp_add(S_RD); exp_add(20'h0);
        base = got_n;
        issue(1'b0, a, 16'h0);
        wait_end(n);
        check(rsp_done == 1, "R9", "read done", rsp_done, 1);
        check(rsp_rdata == exp_d, "R6", "read data", rsp_rdata, exp_d);
        check_seq(base, "R3/R4/R6 read");
    endtask

    task automatic t_ignored();
        int base, n;
        exp_clear();
        exp_add(20'h0003); exp_add(S_CA | 20'h3); exp_add(20'h0003);
        exp_add(20'h1234); exp_add(S_CD | 20'h1234); exp_add(20'h1234);
        exp_add(S_WR); exp_add(20'h1234); exp_add(20'h0);
        base = got_n;
        issue(1'b1, 16'h0003, 16'h1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0007; cmd_wdata = 16'hBEEF;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        wait_end(n);
        check(rsp_done == 1, "R2", "first write completes", rsp_done, 1);
        check_seq(base, "R2 busy ignore");
        t_read(16'h0007, 16'h5A07);   // R2: register 7 untouched
    endtask

    task automatic t_timeout_high();
        int n;
        force_en = 1'b1; force_val = 1'b0;
        issue(1'b0, 16'h0005, 16'h0);
        wait_end(n);
        check(n == 2 + 9 * GAP, "R7", "timeout edge in ack-high wait", n, 2 + 9 * GAP);
        check(rsp_timeout == 1 && rsp_done == 0, "R8", "timeout flag, no done",
              {rsp_timeout, rsp_done}, 2'b10);
        check(phy_ctrl == 0 && busy == 0, "R8", "ctrl cleared and idle",
              {busy, phy_ctrl}, 0);
        repeat (20) @(posedge clk); #1;
        check(rsp_timeout == 1, "R8", "timeout held while idle", rsp_timeout, 1);
    endtask

    task automatic t_timeout_low();
        int n;
        force_en = 1'b1; force_val = 1'b1;
        issue(1'b1, 16'h0006, 16'h0101);
        check(rsp_timeout == 0, "R8", "timeout cleared on accept", rsp_timeout, 1'b0);
        wait_end(n);
        check(n == 3 + 9 * GAP, "R7", "timeout edge in ack-low wait", n, 3 + 9 * GAP);
        check(rsp_timeout == 1 && phy_ctrl == 0, "R8", "timeout in ack-low wait",
              {rsp_timeout, phy_ctrl}, 21'h100000);
        force_en = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic t_last_poll();
        int n;
        force_en = 1'b1; force_val = 1'b0;
        issue(1'b0, 16'h0002, 16'h0);
        repeat (1 + 9 * GAP) @(posedge clk);
        #1 force_val = 1'b1;     // present at the tenth poll
        @(posedge clk);
        #1 force_en = 1'b0;
        wait_end(n);
        check(rsp_done == 1 && rsp_timeout == 0, "R7", "match on last poll succeeds",
              {rsp_done, rsp_timeout}, 2'b10);
        check(rsp_rdata == 16'hA5C3, "R7", "read data after last-poll ack",
              rsp_rdata, 16'hA5C3);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_write(16'h0002, 16'hA5C3);
        t_write(16'h0004, 16'hFFFF);
        t_write(16'h0009, 16'h0000);
        t_read(16'h0002, 16'hA5C3);
        t_read(16'h0004, 16'hFFFF);
        t_read(16'h0009, 16'h0000);
        t_read(16'h000B, 16'h5A0B);
        t_ignored();
        t_timeout_high();
        t_timeout_low();
        t_last_poll();
        repeat (5) @(posedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

endmodule